// File: doc/BRIEF.md
# Fracturable six-input lookup table

This block is a configurable lookup table with six logic inputs. A 64-bit truth-table vector sits at the leaves of a binary tree of 2:1 multiplexers. Each tree stage is steered by one logic input, and input 0 steers the stage nearest the memory. In full mode the root of the tree gives any function of all six inputs.

In fracturable mode, mode-select bits pin chosen inputs to constants. An input pinned to 1 passes through an OR gate, and an input pinned to 0 passes through an AND gate. Separate outputs are tapped from the fourth stage of the tree. Each tapped node is the result of one 4-input sub-table that uses 16 consecutive truth-table bits. A parameter mask chooses which of the four sub-table results appear on the fractured output port.

The block is purely combinational. Configuration loading happens outside it, and the bits arrive as a parallel vector. The set of pinned inputs, their constant values and the output mask are parameters. The widths of the mode-select port and the fractured port must equal the number of ones in the pin map and in the mask.

Top module: `frac_lut6`

## Requirements
- R1: With every mode-select bit at 0, full_o equals cfg_i[idx], where idx is the 6-bit number formed by in_i with in_i[0] as its least significant bit.
- R2: An input marked in FORCE_EN with a 1 in FORCE_ONE (OR-gated; by default inputs 4 and 5) is taken as logic 1 by the tree whenever its mode-select bit is 1, whatever its pin level.
- R3: An input marked in FORCE_EN with a 0 in FORCE_ONE (AND-gated) is taken as logic 0 by the tree whenever its mode-select bit is 1, whatever its pin level.
- R4: Bit j of mode_i controls the j-th forced input, counting upward from the lowest input index. Each forced input is affected only by its own bit, and inputs not marked in FORCE_EN are never affected by mode_i.
- R5: frac_o[m] equals cfg_i[16*k + s]. Here k is the position of the m-th set bit of FRAC_MASK, counting from bit 0, and s is the gated value of inputs 3..0. The default mask 4'b0101 exposes sub-tables 0 and 2 on frac_o[0] and frac_o[1].
- R6: The gating of inputs below index 4 also applies to the fractured outputs: a forced low input selects within every 4-input sub-table as its constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_i | input | N_IN (6) | Logic inputs; in_i[0] drives the stage nearest the memory |
| cfg_i | input | 2**N_IN (64) | Truth-table configuration bits |
| mode_i | input | MODE_W (2) | Mode-select bits, one per forced input, lowest input first |
| full_o | output | 1 | Root of the tree: the full 6-input result |
| frac_o | output | N_FRAC (2) | 4-input sub-table results chosen by FRAC_MASK |

## Verification
Two instances are exercised. The first has the default high inputs OR-forced and a sparse mask. The second has inputs 0 and 1 AND-forced and every sub-table exposed. For each instance, random truth tables are swept over all 64 input combinations under each of the four mode-select patterns. Patterns 01 and 10 separate a correct mode-bit-to-input ordering from a swapped one, and pattern 11 separates OR from AND forcing. Directed tables (all zeros, all ones, a single set bit at the top address, and a single set bit inside sub-table 2) expose an off-by-one in the tree indexing or a wrongly chosen tap.

// File: rtl/frac_lut6.sv
module frac_lut6 #(
  parameter int N_IN = 6,
  parameter int TAP = 4,
  parameter logic [N_IN-1:0] FORCE_EN = 6'b110000,
  parameter logic [N_IN-1:0] FORCE_ONE = 6'b110000,
  parameter logic [(1<<(N_IN-TAP))-1:0] FRAC_MASK = 4'b0101,
  parameter int MODE_W = 2,
  parameter int N_FRAC = 2
) (
  input  logic [N_IN-1:0]      in_i,
  input  logic [(1<<N_IN)-1:0] cfg_i,
  input  logic [MODE_W-1:0]    mode_i,
  output logic                 full_o,
  output logic [N_FRAC-1:0]    frac_o
);

  localparam int DEPTH = 1 << N_IN;
  localparam int SUBS = 1 << (N_IN - TAP);
  localparam int SUBW = 1 << TAP;

  function automatic int mode_pos(input int idx);
    int n = 0;
    for (int k = 0; k < idx; k++) if (FORCE_EN[k]) n++;
    return n;
  endfunction

  function automatic int tap_pos(input int m);
    int n = 0;
    int pos = 0;
    for (int k = 0; k < SUBS; k++) begin
      if (FRAC_MASK[k]) begin
        if (n == m) pos = k;
        n++;
      end
    end
    return pos;
  endfunction

  logic [N_IN-1:0] gin;

  for (genvar i = 0; i < N_IN; i++) begin : gate
    if (FORCE_EN[i] && FORCE_ONE[i]) begin : g_or
      assign gin[i] = in_i[i] | mode_i[mode_pos(i)];
      always_comb
        if (!$isunknown({in_i[i], mode_i}))
          assert_or_force_R2: assert final (!mode_i[mode_pos(i)] || gin[i]);
    end else if (FORCE_EN[i]) begin : g_and
      assign gin[i] = in_i[i] & ~mode_i[mode_pos(i)];
      always_comb
        if (!$isunknown({in_i[i], mode_i}))
          assert_and_force_R3: assert final (!mode_i[mode_pos(i)] || !gin[i]);
    end else begin : g_pass
      assign gin[i] = in_i[i];
      always_comb
        if (!$isunknown({in_i[i], mode_i}))
          assert_pass_through_R4: assert final (gin[i] == in_i[i]);
    end
  end

  for (genvar s = 0; s <= N_IN; s++) begin : stg
    logic [(DEPTH>>s)-1:0] v;
    if (s == 0) begin : leaf
      assign v = cfg_i;
    end else begin : node
      for (genvar j = 0; j < (DEPTH >> s); j++) begin : mx
        assign v[j] = gin[s-1] ? stg[s-1].v[2*j+1] : stg[s-1].v[2*j];
      end
    end
  end

  assign full_o = stg[N_IN].v[0];

  for (genvar m = 0; m < N_FRAC; m++) begin : frac
    assign frac_o[m] = stg[TAP].v[tap_pos(m)];
    always_comb
      if (!$isunknown({in_i, cfg_i, mode_i}))
        assert_frac_tap_R5: assert final
          (frac_o[m] == cfg_i[tap_pos(m)*SUBW + int'(gin[TAP-1:0])]);
  end

  always_comb
    if (!$isunknown({in_i, cfg_i, mode_i}))
      assert_full_lookup_R1: assert final (full_o == cfg_i[gin]);

endmodule

// File: tb/tb_frac_lut6.sv
module tb_frac_lut6;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [5:0]  in_v = '0;
  logic [63:0] cfg_v = '0;
  logic [1:0]  mode_a = '0, mode_b = '0;
  logic        full_a, full_b;
  logic [1:0]  frac_a;
  logic [3:0]  frac_b;
  int checks = 0, fails = 0;
  bit done = 0;

  frac_lut6 dut (.in_i(in_v), .cfg_i(cfg_v), .mode_i(mode_a),
                 .full_o(full_a), .frac_o(frac_a));

  frac_lut6 #(.FORCE_EN(6'b000011), .FORCE_ONE(6'b000000),
              .FRAC_MASK(4'b1111), .MODE_W(2), .N_FRAC(4))
    dut_alt (.in_i(in_v), .cfg_i(cfg_v), .mode_i(mode_b),
             .full_o(full_b), .frac_o(frac_b));

  function automatic logic [5:0] gated(logic [5:0] x, logic [5:0] en,
                                       logic [5:0] one, logic [1:0] md);
    int j = 0;
    logic [5:0] r = x;
    for (int i = 0; i < 6; i++) begin
      if (en[i]) begin
        if (md[j]) r[i] = one[i];
        j++;
      end
    end
    return r;
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s in=%b cfg=%h ma=%b mb=%b actual=%b expected=%b",
               tag, in_v, cfg_v, mode_a, mode_b, got, exp);
    end
  endtask

  function automatic string tag_of(logic [1:0] md, string forced);
    if (md == 2'b00) return "R1";
    if (md == 2'b11) return forced;
    return "R4";
  endfunction

  task automatic sweep();
    for (int x = 0; x < 64; x++) begin
      logic [5:0] ga, gb;
      @(posedge clk);
      in_v = 6'(x);
      @(negedge clk);
      ga = gated(in_v, 6'b110000, 6'b110000, mode_a);
      gb = gated(in_v, 6'b000011, 6'b000000, mode_b);
      chk(tag_of(mode_a, "R2"), full_a, cfg_v[ga]);
      chk(tag_of(mode_b, "R3"), full_b, cfg_v[gb]);
      chk("R5", frac_a[0], cfg_v[0*16 + int'(ga[3:0])]);
      chk("R5", frac_a[1], cfg_v[2*16 + int'(ga[3:0])]);
      for (int k = 0; k < 4; k++)
        chk("R6", frac_b[k], cfg_v[k*16 + int'(gb[3:0])]);
    end
  endtask

  task automatic all_modes();
    for (int md = 0; md < 4; md++) begin
      mode_a = 2'(md);
      mode_b = 2'(3 - md);
      sweep();
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    cfg_v = '0;          all_modes();
    cfg_v = '1;          all_modes();
    cfg_v = 64'h1 << 63; all_modes();
    cfg_v = 64'h1 << 37; all_modes();
    for (int t = 0; t < 6; t++) begin
      cfg_v = {$urandom(), $urandom()};
      all_modes();
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule